// File: doc/BRIEF.md
# Masked Fast GPIO Port

This block is a 32-bit general-purpose I/O port controller that sits on a simple single-cycle local register bus. Software sees five registers: a per-bit direction register, a mask register, a pin-value register, a set register and a clear register. The direction register drives the pad output enables directly. The pin-value register returns the synchronised pad levels when read and loads the output latch when written. The set and clear registers raise or lower any group of output bits in one bus access without a read-modify-write.

The mask register makes a subset of the port behave as a group. A mask bit of 1 protects that bit: writes through the pin-value, set and clear registers leave it untouched, and reads of the pin-value and output readback return 0 there. Every register honours the four byte enables, so 8-bit, 16-bit and 32-bit accesses all work. Pad inputs pass through a two-flop synchroniser, so a pin level can be read at any time, whatever drives the pin.

Top module: `masked_gpio_port`

## Requirements
- R1: After reset the direction, mask and output registers are all 0, so pad_oe and pad_out are 0.
- R2: pad_oe bit n equals direction bit n (1 = output). The direction register is at word address 0x00 and is not filtered by the mask.
- R3: A write to the set register at 0x18 drives to 1 each enabled, unmasked output bit written 1. Bits written 0 are unchanged.
- R4: A write to the clear register at 0x1C drives to 0 each enabled, unmasked output bit written 1. Bits written 0 are unchanged.
- R5: A write to the pin-value register at 0x14 loads every enabled, unmasked output bit from the write data in one access.
- R6: Output bits whose mask bit (register at 0x10) is 1 are not changed by writes to 0x14, 0x18 or 0x1C.
- R7: bus_be[k] enables byte lane k (bits 8k+7..8k) of a write. Bits in disabled lanes of any register keep their value.
- R8: A read of 0x14 returns the pad levels after a two-flop synchroniser, ANDed with the inverted mask. This holds whatever the direction bits are.
- R9: A read of 0x18 returns the output register ANDed with the inverted mask. Reads of 0x00 and 0x10 return the direction and mask registers unfiltered.
- R10: A read returns data with bus_rvalid high in the cycle after the request. The clear register and the unused word addresses 0x04, 0x08 and 0x0C read as 0, and writes to the unused addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access request, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address; bits 4..2 select the register |
| bus_be | input | 4 | Byte-lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | High for one cycle after a read request |
| pad_in | input | 32 | Asynchronous pad levels |
| pad_out | output | 32 | Output latch value to the pads |
| pad_oe | output | 32 | Per-pad output enable, 1 = drive |

## Verification
The assertions assume that each bus request lasts exactly one cycle and that bus_sel, bus_wr, bus_addr and bus_be carry known values at every clock edge. The stimulus changes these inputs only at falling edges and drops bus_sel after each access. Pad inputs are treated as asynchronous, so the properties never relate pad_in to read data directly. The bench changes pad_in only while the bus is idle and waits out the synchroniser before it reads the pin-value register.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [2:0] {
    RK_DIR  = 3'd0,
    RK_MASK = 3'd1,
    RK_PIN  = 3'd2,
    RK_SET  = 3'd3,
    RK_CLR  = 3'd4,
    RK_NONE = 3'd5
  } reg_kind_e;

  // word index = byte address / 4
  localparam logic [2:0] IDX_DIR  = 3'd0;
  localparam logic [2:0] IDX_MASK = 3'd4;
  localparam logic [2:0] IDX_PIN  = 3'd5;
  localparam logic [2:0] IDX_SET  = 3'd6;
  localparam logic [2:0] IDX_CLR  = 3'd7;

  function automatic reg_kind_e kind_of_index(input logic [2:0] idx);
    case (idx)
      IDX_DIR:  return RK_DIR;
      IDX_MASK: return RK_MASK;
      IDX_PIN:  return RK_PIN;
      IDX_SET:  return RK_SET;
      IDX_CLR:  return RK_CLR;
      default:  return RK_NONE;
    endcase
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= async_in;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_decode.sv
module gpio_decode
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int W      = 32
) (
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W/8-1:0]    bus_be,
  output reg_kind_e         wr_kind,
  output reg_kind_e         rd_kind,
  output logic              rd_req,
  output logic [W-1:0]      wr_lanes
);
  localparam int LANES = W / 8;

  logic      upper_zero;
  reg_kind_e hit_kind;

  generate
    if (ADDR_W > 5) begin : g_upper
      assign upper_zero = (bus_addr[ADDR_W-1:5] == '0);
    end else begin : g_noupper
      assign upper_zero = 1'b1;
    end
    for (genvar k = 0; k < LANES; k++) begin : g_lane
      assign wr_lanes[8*k +: 8] = {8{bus_be[k]}};
    end
  endgenerate

  assign hit_kind = upper_zero ? kind_of_index(bus_addr[4:2]) : RK_NONE;
  assign wr_kind  = (bus_sel && bus_wr)  ? hit_kind : RK_NONE;
  assign rd_req   = bus_sel && !bus_wr;
  assign rd_kind  = rd_req ? hit_kind : RK_NONE;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_port_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  reg_kind_e    wr_kind,
  input  logic [W-1:0] wr_lanes,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] mask_q,
  output logic [W-1:0] out_q,
  output logic [W-1:0] out_allow
);
  // replace bits selected by allow, keep the rest
  function automatic logic [W-1:0] merge_bits(input logic [W-1:0] old_v,
                                               input logic [W-1:0] new_v,
                                               input logic [W-1:0] allow);
    return (old_v & ~allow) | (new_v & allow);
  endfunction

  function automatic logic [W-1:0] next_out(input reg_kind_e k,
                                            input logic [W-1:0] cur,
                                            input logic [W-1:0] d,
                                            input logic [W-1:0] allow);
    case (k)
      RK_PIN:  return merge_bits(cur, d, allow);
      RK_SET:  return cur | (d & allow);
      RK_CLR:  return cur & ~(d & allow);
      default: return cur;
    endcase
  endfunction

  assign out_allow = wr_lanes & ~mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      mask_q <= '0;
      out_q  <= '0;
    end else begin
      if (wr_kind == RK_DIR)  dir_q  <= merge_bits(dir_q, wdata, wr_lanes);
      if (wr_kind == RK_MASK) mask_q <= merge_bits(mask_q, wdata, wr_lanes);
      out_q <= next_out(wr_kind, out_q, wdata, out_allow);
    end
  end
endmodule

// File: rtl/gpio_rdmux.sv
module gpio_rdmux
  import gpio_port_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd_req,
  input  reg_kind_e    rd_kind,
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] mask_q,
  input  logic [W-1:0] out_q,
  input  logic [W-1:0] pin_sync,
  output logic [W-1:0] rdata,
  output logic         rvalid
);
  logic [W-1:0] sel_data;

  always_comb begin
    case (rd_kind)
      RK_DIR:  sel_data = dir_q;
      RK_MASK: sel_data = mask_q;
      RK_PIN:  sel_data = pin_sync & ~mask_q;
      RK_SET:  sel_data = out_q & ~mask_q;
      default: sel_data = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_req;
      if (rd_req) rdata <= sel_data;
    end
  end
endmodule

// File: rtl/masked_gpio_port.sv
module masked_gpio_port
  import gpio_port_pkg::*;
#(
  parameter int PORT_W      = 32,
  parameter int ADDR_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [PORT_W/8-1:0] bus_be,
  input  logic [PORT_W-1:0]   bus_wdata,
  output logic [PORT_W-1:0]   bus_rdata,
  output logic                bus_rvalid,
  input  logic [PORT_W-1:0]   pad_in,
  output logic [PORT_W-1:0]   pad_out,
  output logic [PORT_W-1:0]   pad_oe
);
  reg_kind_e         wr_kind;
  reg_kind_e         rd_kind;
  logic              rd_req;
  logic [PORT_W-1:0] wr_lanes;
  logic [PORT_W-1:0] dir_q;
  logic [PORT_W-1:0] mask_q;
  logic [PORT_W-1:0] out_q;
  logic [PORT_W-1:0] out_allow;
  logic [PORT_W-1:0] pin_sync;

  gpio_decode #(.ADDR_W(ADDR_W), .W(PORT_W)) u_dec (
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_be   (bus_be),
    .wr_kind  (wr_kind),
    .rd_kind  (rd_kind),
    .rd_req   (rd_req),
    .wr_lanes (wr_lanes)
  );

  gpio_bank #(.W(PORT_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_kind   (wr_kind),
    .wr_lanes  (wr_lanes),
    .wdata     (bus_wdata),
    .dir_q     (dir_q),
    .mask_q    (mask_q),
    .out_q     (out_q),
    .out_allow (out_allow)
  );

  gpio_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pad_in),
    .sync_out (pin_sync)
  );

  gpio_rdmux #(.W(PORT_W)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_req   (rd_req),
    .rd_kind  (rd_kind),
    .dir_q    (dir_q),
    .mask_q   (mask_q),
    .out_q    (out_q),
    .pin_sync (pin_sync),
    .rdata    (bus_rdata),
    .rvalid   (bus_rvalid)
  );

  assign pad_out = out_q;
  assign pad_oe  = dir_q;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_port_pkg::*;
#(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input reg_kind_e    wr_kind,
  input logic         rd_req,
  input logic [W-1:0] wr_lanes,
  input logic [W-1:0] mask_q,
  input logic [W-1:0] pad_out,
  input logic [W-1:0] pad_oe,
  input logic         bus_rvalid
);
  // R2: enables move only on a direction write
  a_r2_oe_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_kind != RK_DIR) |=> $stable(pad_oe));

  // R3: set never lowers a bit
  a_r3_set_no_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_kind == RK_SET) |=> (($past(pad_out) & ~pad_out) == '0));

  // R4: clear never raises a bit
  a_r4_clr_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_kind == RK_CLR) |=> ((~$past(pad_out) & pad_out) == '0));

  // R5: outputs hold without an output-path write
  a_r5_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_kind inside {RK_PIN, RK_SET, RK_CLR}) |=> $stable(pad_out));

  // R6: protected bits hold across output-path writes
  a_r6_mask_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_kind inside {RK_PIN, RK_SET, RK_CLR}) |=>
      (((pad_out ^ $past(pad_out)) & $past(mask_q)) == '0));

  // R7: disabled lanes hold
  a_r7_lane_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_kind != RK_NONE) |=>
      (((pad_out ^ $past(pad_out)) & ~$past(wr_lanes)) == '0) &&
      (((pad_oe ^ $past(pad_oe)) & ~$past(wr_lanes)) == '0));

  // R10: one response per request, one cycle later
  a_r10_rvalid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> bus_rvalid);
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !bus_rvalid);
endmodule

bind masked_gpio_port gpio_port_chk #(.W(PORT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_kind    (wr_kind),
  .rd_req     (rd_req),
  .wr_lanes   (wr_lanes),
  .mask_q     (mask_q),
  .pad_out    (pad_out),
  .pad_oe     (pad_oe),
  .bus_rvalid (bus_rvalid)
);

// File: tb/masked_gpio_port_test.sv
module masked_gpio_port_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out;
  logic [31:0] pad_oe;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  logic [31:0] m_dir = '0, m_mask = '0, m_out = '0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5ns clk = ~clk;

  masked_gpio_port uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // model of one write, bit by bit
  task automatic bus_write(input logic [4:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    for (int i = 0; i < 32; i++) begin
      if (be[i/8]) begin
        case (a)
          5'h00: m_dir[i]  = d[i];
          5'h10: m_mask[i] = d[i];
          5'h14: if (!m_mask[i]) m_out[i] = d[i];
          5'h18: if (!m_mask[i] && d[i]) m_out[i] = 1'b1;
          5'h1C: if (!m_mask[i] && d[i]) m_out[i] = 1'b0;
          default: ;
        endcase
      end
    end
  endtask

  task automatic bus_read(input logic [4:0] a, input string tag);
    logic [31:0] e;
    case (a)
      5'h00: e = m_dir;
      5'h10: e = m_mask;
      5'h14: e = pad_in & ~m_mask;
      5'h18: e = m_out & ~m_mask;
      default: e = '0;
    endcase
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_be = 4'h0;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic check_pads(input string tag);
    check({tag, " pad_out"}, pad_out, m_out);
    check({tag, " pad_oe"},  pad_oe,  m_dir);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        nchk++; nfail++;
        $display("FAIL R10 unexpected rvalid actual=1 expected=0");
      end else begin
        check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check_pads("R1 reset");
    rst_n = 1'b1;
    bus_read(5'h00, "R1 dir after reset");
    bus_read(5'h10, "R1 mask after reset");
    bus_read(5'h18, "R1 out after reset");

    // R2 direction drives enables
    bus_write(5'h00, 4'hF, 32'hFFFF_0000); check_pads("R2 dir full");
    bus_write(5'h00, 4'h1, 32'h0000_00AA); check_pads("R7 dir byte0");
    bus_read(5'h00, "R2 dir readback");

    // R5 whole-port write
    bus_write(5'h14, 4'hF, 32'h1234_5678); check_pads("R5 pin write");
    // R3 / R4
    bus_write(5'h18, 4'hF, 32'h0000_FF00); check_pads("R3 set");
    bus_write(5'h1C, 4'hF, 32'h1200_000F); check_pads("R4 clear");
    bus_read(5'h18, "R9 out readback");

    // R6 mask protects bits
    bus_write(5'h10, 4'hF, 32'hFF00_FF00);
    bus_read(5'h10, "R9 mask readback");
    bus_write(5'h14, 4'hF, 32'hFFFF_FFFF); check_pads("R6 pin under mask");
    bus_write(5'h1C, 4'hF, 32'hFFFF_FFFF); check_pads("R6 clear under mask");
    bus_write(5'h18, 4'hF, 32'h0F0F_0F0F); check_pads("R6 set under mask");
    bus_read(5'h18, "R9 out masked readback");

    // R7 byte lanes on every register
    bus_write(5'h10, 4'h2, 32'h0000_0000); check_pads("R7 mask byte1");
    bus_read(5'h10, "R7 mask lane readback");
    bus_write(5'h18, 4'h4, 32'hFFFF_FFFF); check_pads("R7 set byte2");
    bus_write(5'h1C, 4'h8, 32'hFFFF_FFFF); check_pads("R7 clear byte3");
    bus_write(5'h14, 4'h3, 32'hA5C3_3C5A); check_pads("R7 pin halfword");

    // R8 pins readable through sync, masked, any direction
    @(negedge clk); pad_in = 32'hDEAD_BEEF;
    repeat (3) @(negedge clk);
    bus_read(5'h14, "R8 pin read masked");
    bus_write(5'h10, 4'hF, 32'h0000_0000);
    bus_write(5'h00, 4'hF, 32'hFFFF_FFFF); check_pads("R2 all outputs");
    bus_read(5'h14, "R8 pin read as outputs");
    @(negedge clk); pad_in = 32'h0123_4567;
    repeat (3) @(negedge clk);
    bus_read(5'h14, "R8 pin read new pattern");

    // R10 unused addresses and clear readback
    bus_read(5'h1C, "R10 clear reads zero");
    bus_write(5'h04, 4'hF, 32'hFFFF_FFFF); check_pads("R10 write 0x04");
    bus_write(5'h08, 4'hF, 32'h0000_0000); check_pads("R10 write 0x08");
    bus_write(5'h0C, 4'hF, 32'h5555_5555); check_pads("R10 write 0x0C");
    bus_read(5'h04, "R10 read 0x04");
    bus_read(5'h0C, "R10 read 0x0C");
    bus_read(5'h00, "R10 dir unchanged");

    repeat (3) @(negedge clk);
    check("R10 responses outstanding", exp_q.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule